// File: doc/BRIEF.md
# Acknowledge-Clocked Serial Tone-Code Output

This block sits behind a tone detector and hands each decoded 4-bit tone code to a host over one serial data line. The host watches the detector's early-steering flag. When the flag goes high, the host sends a train of acknowledge pulses. The first rising edge of the acknowledge line captures the code and places its least significant bit on the data pin. Each of the following three rising edges advances to the next bit. Once all four bits have gone out, the pulse counter saturates, and any further pulses are ignored until the steering flag rises again.

The acknowledge line comes from the host without any timing relation to the system clock, so it passes through a two-flop synchroniser before its rising edges are detected. Real silicon of this kind has no power-on reset. To model that, the pulse counter advances on every acknowledge edge whatever the state of the steering flag, and it rearms only when it is saturated. A read that stops early therefore corrupts the next transfer. A burst of dummy pulses sent while the steering flag is low brings the counter from any count back to the idle, saturated state. A synchronous reset exists, but only to give the simulation a defined starting point.

Top module: `ack_serial_out`

## Requirements
- R1: After reset the serial output `sd` is 0 and the pulse counter is saturated. Acknowledge pulses that arrive before a rising edge of `est` therefore leave `sd` at 0.
- R2: Whenever `est` is low, `sd` is 0.
- R3: `ack_in` passes through two synchroniser flops. The effect of an `ack_in` rising edge appears on `sd` after the third rising clock edge at which `ack_in` is sampled high.
- R4: The first acknowledge edge after rearming captures `code_in` and drives `code_in[0]` onto `sd`.
- R5: The second, third and fourth edges present bits 1, 2 and 3 of the captured code, in that order (LSB first). A change of `code_in` after capture has no effect on these bits.
- R6: Between acknowledge edges, `sd` holds the last bit presented while `est` stays high.
- R7: Acknowledge edges after the fourth are ignored, and `sd` keeps bit 3.
- R8: A rising edge of `est` while the counter is saturated rearms the block: the count returns to 0 and `sd` reads 0 until the next acknowledge edge.
- R9: A rising edge of `est` while a read is unfinished (three or fewer pulses) does not rearm. The next edge continues the old sequence and does not capture the new code.
- R10: Acknowledge edges advance the counter even while `est` is low, so four dummy pulses bring any count to the saturated state. A later `est` rise then rearms normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_in | input | 1 | Host acknowledge pulse line, asynchronous |
| est | input | 1 | Early-steering flag from the tone detector, synchronous |
| code_in | input | 4 | Decoded tone code |
| sd | output | 1 | Serial data bit |

## Verification
The assertions check on every cycle that `sd` is 0 while `est` is low, that `sd` stays still when no edge arrives, that the count never exceeds four, that a saturated count ignores edges, that rearming clears the count, and that the first edge captures bit 0 of the code. What only the bench's scenarios can show is the ordering across a whole transfer. That covers the four bits coming out LSB first, an unfinished read carrying over into the next tone, the recovery by dummy pulses, and the exact three-edge latency from `ack_in` to `sd`.

// File: rtl/ackser_pkg.sv
package ackser_pkg;

    localparam int CODE_W_DEF = 4;
    localparam int SYNC_DEF   = 2;

    // Per-transfer datapath of the parallel-to-serial stage
    typedef struct packed {
        logic [CODE_W_DEF-1:0] rest;   // bits still to be sent, next at [0]
        logic                  bit_q;  // bit currently presented
    } ser_data_t;

    function automatic logic first_bit(input logic [CODE_W_DEF-1:0] code);
        return code[0];
    endfunction

    function automatic logic [CODE_W_DEF-1:0] drop_bit(input logic [CODE_W_DEF-1:0] v);
        return v >> 1;
    endfunction

endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
    parameter int STAGES = ackser_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_in,
    output logic rise
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], ack_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/steer_edge.sv
module steer_edge (
    input  logic clk,
    input  logic rst,
    input  logic est,
    output logic est_rise
);
    logic est_q;

    always_ff @(posedge clk) begin
        if (rst) est_q <= 1'b0;
        else     est_q <= est;
    end

    assign est_rise = est & ~est_q;
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
    import ackser_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    localparam int CNT_W = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              est_rise,
    input  logic [CODE_W-1:0] code_in,
    output logic              rearm,
    output logic [CNT_W-1:0]  cnt,
    output logic              bit_q
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

    ser_data_t        dat;
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full  = (cnt_q == FULL);
    assign rearm = est_rise & full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= FULL;
            dat   <= '0;
        end else if (rearm) begin
            cnt_q     <= '0;
            dat.bit_q <= 1'b0;
        end else if (step && !full) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) begin
                dat.bit_q <= first_bit(code_in);
                dat.rest  <= drop_bit(code_in);
            end else begin
                dat.bit_q <= dat.rest[0];
                dat.rest  <= drop_bit(dat.rest);
            end
        end
    end

    assign cnt   = cnt_q;
    assign bit_q = dat.bit_q;
endmodule

// File: rtl/ack_serial_out.sv
module ack_serial_out
    import ackser_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    localparam int CNT_W = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_in,
    input  logic              est,
    input  logic [CODE_W-1:0] code_in,
    output logic              sd
);
    logic             ack_rise;
    logic             est_rise;
    logic             rearm;
    logic [CNT_W-1:0] cnt;
    logic             bit_q;

    ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ack_in(ack_in), .rise(ack_rise)
    );

    steer_edge u_steer (
        .clk(clk), .rst(rst), .est(est), .est_rise(est_rise)
    );

    serial_shifter #(.CODE_W(CODE_W)) u_shift (
        .clk(clk), .rst(rst), .step(ack_rise), .est_rise(est_rise),
        .code_in(code_in), .rearm(rearm), .cnt(cnt), .bit_q(bit_q)
    );

    assign sd = est & bit_q;
endmodule

// File: rtl/ack_serial_out_chk.sv
module ack_serial_out_chk #(
    parameter int CODE_W = 4,
    parameter int CNT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              est,
    input logic              sd,
    input logic              rise,
    input logic              rearm,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] code_in
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        !est |-> !sd);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (est && !rise && !rearm) |=> (!est || $stable(sd)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    p_ignore_extra_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && rise && !rearm) |=> (cnt == FULL));

    p_rearm_clear_r8: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (cnt == '0 && !sd));

    p_first_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && rise && !rearm && est) |=> (!est || sd == $past(code_in[0])));
endmodule

bind ack_serial_out ack_serial_out_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .est(est), .sd(sd), .rise(ack_rise),
    .rearm(rearm), .cnt(cnt), .code_in(code_in)
);

// File: tb/sim_ack_serial_out.sv
`timescale 1ns/1ps
module sim_ack_serial_out;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ack_in = 1'b0;
    logic       est = 1'b0;
    logic [3:0] code_in = 4'h0;
    logic       sd;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit started = 0;

    always #2.5 clk = ~clk;

    ack_serial_out u0 (.clk(clk), .rst(rst), .ack_in(ack_in), .est(est),
                       .code_in(code_in), .sd(sd));

    // behavioural reference: history of acknowledge samples, a counter, a word
    logic hist[$];
    int   m_cnt;
    logic [3:0] m_word;
    logic m_bit;
    logic est_prev;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_cnt = 4; m_bit = 1'b0; est_prev = 1'b0; m_word = 4'h0;
        end else begin
            if (est && !est_prev && m_cnt == 4) begin
                m_cnt = 0; m_bit = 1'b0;
            end else if (hist[1] && !hist[2] && m_cnt < 4) begin
                if (m_cnt == 0) m_word = code_in;
                m_bit = m_word[m_cnt];
                m_cnt++;
            end
            est_prev = est;
            hist.push_front(ack_in);
            void'(hist.pop_back());
        end
        started = 1;
        #1;
        total++;
        if (sd !== (est & m_bit)) begin
            bad++;
            $display("FAIL %s cycle compare: sd=%b expected=%b", cur_req, sd, est & m_bit);
        end
    end

    task automatic check(input string req, input logic exp);
        total++;
        if (sd !== exp) begin
            bad++;
            $display("FAIL %s: sd=%b expected=%b", req, sd, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) ack_in = 1'b1;
        repeat (4) @(negedge clk);
        ack_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_est(input logic v);
        @(negedge clk) est = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0);
        // R1 / R10: a pulse while saturated after reset, est low
        cur_req = "R1"; code_in = 4'hF; pulse(); check("R1", 1'b0);

        // R8 rearm, then R4/R5 full read of 1011
        cur_req = "R8"; set_est(1'b1); check("R8", 1'b0);
        code_in = 4'b1011;
        cur_req = "R4"; pulse(); check("R4", 1'b1);
        code_in = 4'b0000;
        cur_req = "R5"; pulse(); check("R5", 1'b1);
        pulse(); check("R5", 1'b0);
        pulse(); check("R5", 1'b1);
        cur_req = "R6"; repeat (10) @(negedge clk); check("R6", 1'b1);
        cur_req = "R7"; pulse(); pulse(); check("R7", 1'b1);
        cur_req = "R2"; set_est(1'b0); check("R2", 1'b0);

        // R3 latency on code 0001
        cur_req = "R3"; code_in = 4'b0001; set_est(1'b1);
        @(negedge clk) ack_in = 1'b1;
        repeat (2) @(negedge clk); check("R3", 1'b0);
        @(negedge clk); check("R3", 1'b1);
        repeat (2) @(negedge clk); ack_in = 1'b0; repeat (4) @(negedge clk);
        pulse(); pulse(); pulse(); check("R3", 1'b0);
        set_est(1'b0);

        // R9 short read of 0110, then a new tone 1001
        cur_req = "R9"; code_in = 4'b0110; set_est(1'b1);
        pulse(); check("R9", 1'b0);
        pulse(); check("R9", 1'b1);
        pulse(); check("R9", 1'b1);
        set_est(1'b0);
        code_in = 4'b1001; set_est(1'b1);
        pulse(); check("R9", 1'b0);
        pulse(); check("R9", 1'b0);
        set_est(1'b0);

        // R10 unfinished read then dummy pulses with est low
        cur_req = "R10"; code_in = 4'b1100; set_est(1'b1);
        pulse(); check("R10", 1'b0);
        set_est(1'b0);
        pulse(); pulse(); pulse(); check("R10", 1'b0);
        code_in = 4'b0101; set_est(1'b1); check("R10", 1'b0);
        pulse(); check("R10", 1'b1);
        pulse(); check("R10", 1'b0);
        pulse(); check("R10", 1'b1);
        pulse(); check("R10", 1'b0);
        set_est(1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule